// File: doc/BRIEF.md
# Time-Sliced Multichannel Host Bus Front End

This block connects an asynchronous, active-low host bus to a multichannel serial controller. The controller's channels share one datapath and are visited in turn by a slot counter. The host presents a chip select, separate read and write strobes, an address and write data. The block samples all of them with the system clock. A strobe is qualified only after two consecutive low samples. The upper address bits pick a channel and the low three bits pick a register in that channel.

Read data comes from a per-channel register bank as soon as the strobe qualifies. A write is held pending until the slot counter reaches the target channel, and is committed on that cycle. The time-sliced datapath needs idle time between strobes, and that recovery time depends on the pair of accesses:

- A plain gap applies in the general case.
- A short gap applies to back-to-back FIFO accesses of the same kind.
- A long gap applies before reading modem status after loopback has been enabled.

A busy output shows the recovery window still running. A strobe that arrives too early is dropped and sets a sticky violation flag. The modem status register follows modem control through a delayed loopback update.

Top module: `mch_host_if`

## Requirements
- R1: A strobe is qualified only when cs_n and that strobe are both sampled low on two consecutive rising clock edges. A strobe that is low for a single edge causes no access, no busy and no output enable.
- R2: For a qualified read, rdata_oe is high and rdata carries the register value when sampled after the second rising edge that follows the first low sample. rdata_oe falls as soon as rd_n or cs_n goes high, and rdata is zero whenever rdata_oe is low.
- R3: addr[2:0] is the register offset and the bits above it are the channel index. A write is committed when the slot counter, which steps one channel per clock and wraps after NUM_CH-1, equals the channel, so the commit happens within NUM_CH cycles. A later read of the same channel and offset returns the written value.
- R4: The gap is the number of rising edges with both strobes sampled inactive between two qualified strobes. By default an access is accepted only if the gap is at least 3*NUM_CH+3.
- R5: A FIFO read (offset 0) after a FIFO read of the same channel needs a gap of only 4. A FIFO write after any FIFO write also needs a gap of only 4. A FIFO read after a FIFO read of a different channel needs the default gap.
- R6: A read of modem status (offset 6) after an accepted write to modem control (offset 4) with bit 4 (loopback) set needs a gap of at least 8*NUM_CH+3.
- R7: Modem status is read-only. After a modem control write with bit 4 set, status bits 7:4 become {MCR[3], MCR[2], MCR[0], MCR[1]} within 3*NUM_CH+1 cycles of the commit. If bit 4 is clear, status becomes zero. Status bits 3:0 are always zero.
- R8: busy is high while a qualified strobe is held. After release it stays high until the gap reaches 3*NUM_CH+3, or 8*NUM_CH+3 when the last accepted access was a loopback modem control write.
- R9: A qualified strobe whose gap is below its requirement sets viol, which stays set until reset. Such an access is ignored: no register changes and rdata_oe stays low.
- R10: During and after reset, busy, viol and rdata_oe are low and rdata is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | CH_W+3 | Channel index (upper bits) and register offset (bits 2:0) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when not enabled |
| rdata_oe | output | 1 | Enable for the pad driver of the read data bus |
| busy | output | 1 | Strobe held or recovery window running |
| viol | output | 1 | Sticky recovery-timing violation |

## Verification
A strobe is qualified on its second low sample. The access is decided on the following edge, so read data and output enable are due after the third rising edge of a held strobe. The bench drives inputs on falling edges and checks there, before releasing the strobe. Gaps are set by counting high edges exactly, which lets each vector sit at or just below a threshold. A write's effect is observed through a later read whose gap is long enough to cover the slot wait and the loopback delay. The busy window is checked on the last edge before it closes and on the first edge after.

// File: rtl/mch_pkg.sv
package mch_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HRD, ST_HWR, ST_IGN} hst_e;

  localparam logic [2:0] OFF_FIFO = 3'd0;
  localparam logic [2:0] OFF_MCR  = 3'd4;
  localparam logic [2:0] OFF_MSR  = 3'd6;
  localparam int         MCR_LOOP = 4;
endpackage

// File: rtl/mch_strobe_filter.sv
module mch_strobe_filter (
  input  logic clk,
  input  logic rst,
  input  logic lo_i,
  output logic go_o,
  output logic smp_o
);
  logic [1:0] smp_q;

  always_ff @(posedge clk) begin
    if (rst) smp_q <= '0;
    else     smp_q <= {smp_q[0], lo_i};
  end

  assign go_o  = &smp_q;
  assign smp_o = smp_q[0];

  // R1: qualification needs two low samples in a row
  p_two_samples_r1: assert property (@(posedge clk) disable iff (rst)
    go_o |-> ($past(lo_i) && $past(lo_i, 2)));
endmodule

// File: rtl/mch_slot_ctr.sv
module mch_slot_ctr #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  output logic [CH_W-1:0] slot_o
);
  localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

  always_ff @(posedge clk) begin
    if (rst)                slot_o <= '0;
    else if (slot_o == LAST) slot_o <= '0;
    else                    slot_o <= slot_o + 1'b1;
  end

  p_slot_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (slot_o == LAST) |=> (slot_o == '0));
  p_slot_step_r3: assert property (@(posedge clk) disable iff (rst)
    (slot_o != LAST) |=> (slot_o == $past(slot_o) + 1'b1));
endmodule

// File: rtl/mch_reg_bank.sv
module mch_reg_bank import mch_pkg::*; #(
  parameter int NUM_CH   = 4,
  parameter int CH_W     = 2,
  parameter int DATA_W   = 8,
  parameter int LOOP_DLY = 12,
  localparam int DEPTH   = (1 << CH_W) * 8,
  localparam int CNT_W   = $clog2(LOOP_DLY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic [2:0]        rd_off,
  output logic [DATA_W-1:0] rd_q,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [2:0]        wr_off,
  input  logic [DATA_W-1:0] wr_dat
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] msr [1 << CH_W];
  logic              lp_pend;
  logic [CNT_W-1:0]  lp_cnt;
  logic [CH_W-1:0]   lp_ch;
  logic [DATA_W-1:0] lp_val, lp_next;

  // plain registers: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (wr_en && wr_off != OFF_MSR) mem[{wr_ch, wr_off}] <= wr_dat;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= (rd_off == OFF_MSR) ? msr[rd_ch] : mem[{rd_ch, rd_off}];
  end

  always_comb begin
    lp_next = '0;
    if (wr_dat[MCR_LOOP]) lp_next[7:4] = {wr_dat[3], wr_dat[2], wr_dat[0], wr_dat[1]};
  end

  // modem status follows modem control after a fixed delay
  always_ff @(posedge clk) begin
    if (rst) begin
      lp_pend <= 1'b0;
      lp_cnt  <= '0;
      lp_ch   <= '0;
      lp_val  <= '0;
      for (int i = 0; i < (1 << CH_W); i++) msr[i] <= '0;
    end else if (wr_en && wr_off == OFF_MCR) begin
      lp_pend <= 1'b1;
      lp_cnt  <= CNT_W'(LOOP_DLY);
      lp_ch   <= wr_ch;
      lp_val  <= lp_next;
    end else if (lp_pend) begin
      if (lp_cnt == '0) begin
        msr[lp_ch] <= lp_val;
        lp_pend    <= 1'b0;
      end else begin
        lp_cnt <= lp_cnt - 1'b1;
      end
    end
  end

  p_msr_low_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_off == OFF_MSR) |=> (rd_q[3:0] == 4'h0));
endmodule

// File: rtl/mch_host_if.sv
module mch_host_if import mch_pkg::*; #(
  parameter int  NUM_CH  = 4,
  parameter int  DATA_W  = 8,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W  = CH_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              busy,
  output logic              viol
);
  localparam int GAP_W = $clog2(8 * NUM_CH + 4) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX  = '1;
  localparam logic [GAP_W-1:0] WIN_STD  = GAP_W'(3 * NUM_CH + 3);
  localparam logic [GAP_W-1:0] WIN_LOOP = GAP_W'(8 * NUM_CH + 3);
  localparam logic [GAP_W-1:0] WIN_FIFO = GAP_W'(4);
  localparam logic [CH_W:0]    AGE_LIM  = (CH_W + 1)'(NUM_CH);

  logic rd_lo, wr_lo, rd_go, wr_go, rd_smp, wr_smp;
  logic [CH_W-1:0] slot, cur_ch, last_ch, p_ch;
  logic [2:0] cur_off, p_off;
  logic [DATA_W-1:0] p_dat, bank_q;
  logic [GAP_W-1:0] gap, req, win_last;
  logic [CH_W:0] age;
  hst_e st;
  logic want, is_rd, new_fifo, acc, commit, pend;
  logic last_ok, last_rd, last_fifo, last_loopw;

  assign rd_lo = ~cs_n & ~rd_n;
  assign wr_lo = ~cs_n & ~wr_n;

  mch_strobe_filter u_rdf (.clk(clk), .rst(rst), .lo_i(rd_lo), .go_o(rd_go), .smp_o(rd_smp));
  mch_strobe_filter u_wrf (.clk(clk), .rst(rst), .lo_i(wr_lo), .go_o(wr_go), .smp_o(wr_smp));
  mch_slot_ctr #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_slot (.clk(clk), .rst(rst), .slot_o(slot));

  assign cur_ch   = addr[ADDR_W-1:3];
  assign cur_off  = addr[2:0];
  assign want     = (st == ST_IDLE) && (rd_go || wr_go);
  assign is_rd    = rd_go;
  assign new_fifo = (cur_off == OFF_FIFO);

  // recovery requirement for the pair (last accepted, this one)
  always_comb begin
    req = WIN_STD;
    if (last_ok) begin
      if (is_rd && new_fifo && last_rd && last_fifo && last_ch == cur_ch) req = WIN_FIFO;
      else if (!is_rd && new_fifo && !last_rd && last_fifo)               req = WIN_FIFO;
      else if (is_rd && cur_off == OFF_MSR && last_loopw)                 req = WIN_LOOP;
    end
  end

  assign acc      = want && (gap >= req);
  assign commit   = pend && (slot == p_ch);
  assign win_last = last_loopw ? WIN_LOOP : WIN_STD;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      gap        <= GAP_MAX;
      viol       <= 1'b0;
      last_ok    <= 1'b0;
      last_rd    <= 1'b0;
      last_fifo  <= 1'b0;
      last_loopw <= 1'b0;
      last_ch    <= '0;
    end else begin
      if (want) gap <= '0;
      else if (!rd_lo && !wr_lo && gap != GAP_MAX) gap <= gap + 1'b1;

      case (st)
        ST_IDLE: if (want) st <= acc ? (is_rd ? ST_HRD : ST_HWR) : ST_IGN;
        ST_HRD:  if (!rd_smp) st <= ST_IDLE;
        ST_HWR:  if (!wr_smp) st <= ST_IDLE;
        default: if (!rd_smp && !wr_smp) st <= ST_IDLE;
      endcase

      if (want && !acc) viol <= 1'b1;

      if (acc) begin
        last_ok    <= 1'b1;
        last_rd    <= is_rd;
        last_fifo  <= new_fifo;
        last_loopw <= !is_rd && cur_off == OFF_MCR && wdata[MCR_LOOP];
        last_ch    <= cur_ch;
      end
    end
  end

  // a write waits for its channel's slot
  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      age   <= '0;
      p_ch  <= '0;
      p_off <= '0;
      p_dat <= '0;
    end else if (acc && !is_rd) begin
      pend  <= 1'b1;
      age   <= '0;
      p_ch  <= cur_ch;
      p_off <= cur_off;
      p_dat <= wdata;
    end else if (commit) begin
      pend <= 1'b0;
    end else if (pend) begin
      age <= age + 1'b1;
    end
  end

  mch_reg_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .LOOP_DLY(3 * NUM_CH)) u_bank (
    .clk(clk), .rst(rst),
    .rd_en(acc && is_rd), .rd_ch(cur_ch), .rd_off(cur_off), .rd_q(bank_q),
    .wr_en(commit), .wr_ch(p_ch), .wr_off(p_off), .wr_dat(p_dat)
  );

  assign rdata_oe = (st == ST_HRD) && rd_lo;
  assign rdata    = rdata_oe ? bank_q : '0;
  assign busy     = (st != ST_IDLE) || (gap < win_last);

  p_commit_bound_r3: assert property (@(posedge clk) disable iff (rst)
    pend |-> (age < AGE_LIM));
  p_viol_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    viol |=> viol);
  p_busy_after_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    want |=> busy);
  p_ignored_no_pend_r9: assert property (@(posedge clk) disable iff (rst)
    (want && !acc && !pend) |=> !pend);
endmodule

// File: tb/mch_host_if_test.sv
module mch_host_if_test;
  typedef struct packed {
    logic       rd;
    logic [1:0] ch;
    logic [2:0] off;
    logic [7:0] wd;
    logic [7:0] gap;
    logic       acc;
    logic [7:0] exp;
  } vec_t;

  // N=4: default gap 15, FIFO pair 4, loopback-status 35
  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd1, 3'd0, 8'hA5, 8'd20, 1'b1, 8'h00},  // R3 FIFO write
    '{1'b0, 2'd2, 3'd0, 8'h3C, 8'd4,  1'b1, 8'h00},  // R5 fast write pair
    '{1'b1, 2'd1, 3'd0, 8'h00, 8'd15, 1'b1, 8'hA5},  // R4 default gap
    '{1'b1, 2'd1, 3'd0, 8'h00, 8'd4,  1'b1, 8'hA5},  // R5 fast read same ch
    '{1'b0, 2'd3, 3'd7, 8'h5A, 8'd15, 1'b1, 8'h00},
    '{1'b1, 2'd3, 3'd7, 8'h00, 8'd15, 1'b1, 8'h5A},  // R3
    '{1'b1, 2'd2, 3'd0, 8'h00, 8'd15, 1'b1, 8'h3C},
    '{1'b0, 2'd0, 3'd4, 8'h1B, 8'd15, 1'b1, 8'h00},  // loopback on
    '{1'b1, 2'd0, 3'd6, 8'h00, 8'd35, 1'b1, 8'hB0},  // R6 R7
    '{1'b1, 2'd0, 3'd4, 8'h00, 8'd15, 1'b1, 8'h1B},
    '{1'b0, 2'd0, 3'd4, 8'h05, 8'd15, 1'b1, 8'h00},  // loopback off
    '{1'b1, 2'd0, 3'd6, 8'h00, 8'd15, 1'b1, 8'h00},  // R7
    '{1'b0, 2'd0, 3'd6, 8'hFF, 8'd15, 1'b1, 8'h00},  // R7 read-only
    '{1'b1, 2'd0, 3'd6, 8'h00, 8'd15, 1'b1, 8'h00},
    '{1'b0, 2'd3, 3'd7, 8'h77, 8'd5,  1'b0, 8'h00},  // R9 early write
    '{1'b1, 2'd3, 3'd7, 8'h00, 8'd15, 1'b1, 8'h5A},  // R9 not written
    '{1'b1, 2'd2, 3'd0, 8'h00, 8'd15, 1'b1, 8'h3C},
    '{1'b1, 2'd1, 3'd0, 8'h00, 8'd4,  1'b0, 8'h00},  // R5 other ch -> early
    '{1'b0, 2'd0, 3'd4, 8'h1F, 8'd15, 1'b1, 8'h00},
    '{1'b1, 2'd0, 3'd6, 8'h00, 8'd20, 1'b0, 8'h00}   // R6 too early
  };

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic rdata_oe, busy, viol;
  int errors = 0, checks = 0;
  logic exp_viol = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  mch_host_if #(.NUM_CH(4), .DATA_W(8)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .busy(busy), .viol(viol)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // gap high edges, then a strobe held low for four edges
  task automatic access(input vec_t v);
    repeat (v.gap) @(negedge clk);
    addr  = {v.ch, v.off};
    wdata = v.wd;
    if (v.rd) rd_n = 1'b0; else wr_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_viol = exp_viol | ~v.acc;
    chk("R9 viol", {31'd0, viol}, {31'd0, exp_viol});
    chk("R8 busy held", {31'd0, busy}, 32'd1);
    if (v.rd) begin
      chk("R2 oe", {31'd0, rdata_oe}, {31'd0, v.acc});
      chk("R2 R3 rdata", {24'd0, rdata}, {24'd0, v.exp});
    end
    @(posedge clk);
    @(negedge clk);
    rd_n = 1'b1;
    wr_n = 1'b1;
    #1;
    if (v.rd) chk("R2 oe release", {31'd0, rdata_oe}, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R10 busy", {31'd0, busy}, 32'd0);
    chk("R10 viol", {31'd0, viol}, 32'd0);
    chk("R10 oe", {31'd0, rdata_oe}, 32'd0);
    chk("R10 rdata", {24'd0, rdata}, 32'd0);
    rst = 1'b0;
    cs_n = 1'b0;
    for (int i = 0; i < NV; i++) access(VEC[i]);

    // R8: window after a loopback control write is 35 idle edges
    repeat (34) @(negedge clk);
    chk("R8 busy at 34", {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk("R8 busy at 35", {31'd0, busy}, 32'd0);

    // R1: one-edge glitch is not an access
    repeat (40) @(negedge clk);
    addr = {2'd3, 3'd7};
    rd_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 glitch busy", {31'd0, busy}, 32'd0);
    chk("R1 glitch oe", {31'd0, rdata_oe}, 32'd0);
    chk("R1 glitch rdata", {24'd0, rdata}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule